// File: doc/BRIEF.md
# Chip-Select Framing Sequencer

This block frames each word moved by a serial shift engine with its chip-select line. It takes word requests that name a select line and a hold flag. It pulls that line low and waits a programmed number of clocks. It then fires a one-cycle start pulse at the engine. When the engine reports done, it waits a second programmed number of clocks and raises the line again. An optional idle gap can follow the release.

The 32-bit delay word holds four 8-bit delay fields. Only the top two are used here: bits 31:24 set the select-to-first-clock wait and bits 23:16 set the last-clock-to-release wait. A timer-bypass input turns both waits to zero. When a word carries the hold flag, the select stays low after the word completes and the sequencer accepts the next word at once. If the next word is for the same line, the engine starts on the very next cycle. If it is for another line, the held line is released first with the release wait, and the new line is then asserted.

Top module: `cs_frame_seq`

## Requirements
- R1: After reset all select outputs are high, busy and the engine start pulse are low, and the request-ready output is high.
- R2: During a word exactly one select output is low: bit i of `cs_n` for a request with `req_idx` = i. All other bits stay high.
- R3: With the bypass off, `eng_start` rises N+1 cycles after the select line falls, where N is `cfg_delay[31:24]`.
- R4: With the bypass off, the select line rises N+1 cycles after the cycle in which `eng_done` is sampled high, where N is `cfg_delay[23:16]`.
- R5: With `cfg_timer_dis` high, both delay fields count as zero, so each of the two spacings above is exactly one cycle.
- R6: Bits 15:0 of `cfg_delay` have no effect on any output timing.
- R7: After a word with `req_hold` set completes, its select line stays low and busy is low. A following request for the same line makes `eng_start` high in the cycle right after acceptance, with no release of the line.
- R8: A request for a different line while a line is held releases the held line after the release wait. The new line falls one cycle later and then follows the R3 timing.
- R9: With `cfg_gap_en` high, busy stays high for `cfg_gap` cycles after the select line rises. With `cfg_gap_en` low, busy falls together with the select line.
- R10: `eng_start` is a single-cycle pulse, issued once per word.
- R11: Busy is high from request acceptance until the line is released (and any gap ends), or until the word completes when hold is set. `req_ready` is the inverse of busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the whole block |
| req_valid | input | 1 | Word request, taken when `req_ready` is high |
| req_idx | input | IDX_W (3) | Select line number for the word |
| req_hold | input | 1 | Keep the line low after this word |
| req_ready | output | 1 | Sequencer can take a request |
| cfg_delay | input | 4*DLY_W (32) | Packed delay fields; [31:24] select-to-start, [23:16] done-to-release |
| cfg_timer_dis | input | 1 | Bypass both delays |
| cfg_gap_en | input | 1 | Enable idle gap after release |
| cfg_gap | input | GAP_W (6) | Idle gap length in cycles |
| eng_done | input | 1 | Shift engine finished the word |
| eng_start | output | 1 | One-cycle start pulse to the shift engine |
| cs_n | output | NUM_CS (8) | Active-low select lines |
| busy | output | 1 | Sequence in progress |

## Verification
Every line number is swept against several select-to-start and done-to-release values, including zero, with the gap both on and off. This separates an off-by-one in either counter from a wrong line decode and from a gap that leaks into busy when it is disabled. Varying the unused low half of the delay word shows those bits have no effect. The held-word cases cover continuing on the same line versus switching lines, and show whether hold skips the assert wait and whether a switch releases the old line before the new one falls. A bypass run with large delay values separates the bypass path from the counter path.

// File: rtl/cs_frame_pkg.sv
package cs_frame_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ASSERT,
      ST_LEAD,
      ST_START,
      ST_XFER,
      ST_TRAIL,
      ST_RELEASE,
      ST_GAP,
      ST_LAUNCH,
      ST_HOLD
   } frame_state_e;

endpackage

// File: rtl/cs_frame_timer.sv
module cs_frame_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - CNT_W'(1);
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/cs_frame_decode.sv
module cs_frame_decode #(
   parameter int NUM_CS     = 8,
   parameter bit ACTIVE_LOW = 1'b1,
   localparam int IDX_W     = $clog2(NUM_CS)
) (
   input  logic              active,
   input  logic [IDX_W-1:0]  idx,
   output logic [NUM_CS-1:0] lines
);

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CS; gi++) begin : g_line
         logic hit;
         assign hit = active && (idx == IDX_W'(gi));
         if (ACTIVE_LOW) begin : g_low
            assign lines[gi] = ~hit;
         end else begin : g_high
            assign lines[gi] = hit;
         end
      end
   endgenerate

endmodule

// File: rtl/cs_frame_seq.sv
module cs_frame_seq
   import cs_frame_pkg::*;
#(
   parameter int NUM_CS = 8,
   parameter int DLY_W  = 8,
   parameter int GAP_W  = 6,
   localparam int IDX_W = $clog2(NUM_CS),
   localparam int CFG_W = 4 * DLY_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [IDX_W-1:0]  req_idx,
   input  logic              req_hold,
   output logic              req_ready,
   input  logic [CFG_W-1:0]  cfg_delay,
   input  logic              cfg_timer_dis,
   input  logic              cfg_gap_en,
   input  logic [GAP_W-1:0]  cfg_gap,
   input  logic              eng_done,
   output logic              eng_start,
   output logic [NUM_CS-1:0] cs_n,
   output logic              busy
);

   localparam int CNT_W = (DLY_W > GAP_W) ? DLY_W : GAP_W;
   localparam int LEAD_HI  = 4 * DLY_W - 1;
   localparam int TRAIL_HI = 3 * DLY_W - 1;

   generate
      if (NUM_CS < 2) begin : g_bad_cs
         $error("cs_frame_seq: NUM_CS must be at least 2");
      end
      if (DLY_W < 1 || GAP_W < 1) begin : g_bad_w
         $error("cs_frame_seq: delay and gap widths must be positive");
      end
   endgenerate

   frame_state_e     state_q, state_d;
   logic [IDX_W-1:0] cur_idx_q, pend_idx_q;
   logic             cur_hold_q, pend_hold_q, pend_q, cs_act_q;
   logic             tmr_load, tmr_zero;
   logic [CNT_W-1:0] tmr_val;
   logic [DLY_W-1:0] lead_eff, trail_eff;
   logic [GAP_W-1:0] gap_eff;

   assign lead_eff  = cfg_timer_dis ? '0 : cfg_delay[LEAD_HI -: DLY_W];
   assign trail_eff = cfg_timer_dis ? '0 : cfg_delay[TRAIL_HI -: DLY_W];
   assign gap_eff   = cfg_gap_en ? cfg_gap : '0;

   cs_frame_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_zero)
   );

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_IDLE: if (req_valid) state_d = ST_ASSERT;
         ST_ASSERT: begin
            if (lead_eff == '0) state_d = ST_START;
            else begin
               state_d  = ST_LEAD;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(lead_eff - DLY_W'(1));
            end
         end
         ST_LEAD:   if (tmr_zero) state_d = ST_START;
         ST_START:  state_d = ST_XFER;
         ST_XFER, ST_HOLD: begin
            if ((state_q == ST_XFER && eng_done && cur_hold_q) ||
                (state_q == ST_HOLD && req_valid && req_idx == cur_idx_q))
               state_d = (state_q == ST_XFER) ? ST_HOLD : ST_START;
            else if ((state_q == ST_XFER && eng_done) ||
                     (state_q == ST_HOLD && req_valid)) begin
               if (trail_eff == '0) state_d = ST_RELEASE;
               else begin
                  state_d  = ST_TRAIL;
                  tmr_load = 1'b1;
                  tmr_val  = CNT_W'(trail_eff - DLY_W'(1));
               end
            end
         end
         ST_TRAIL:  if (tmr_zero) state_d = ST_RELEASE;
         ST_RELEASE: begin
            if (gap_eff != '0) begin
               state_d  = ST_GAP;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(gap_eff - GAP_W'(1));
            end else begin
               state_d = pend_q ? ST_LAUNCH : ST_IDLE;
            end
         end
         ST_GAP:    if (tmr_zero) state_d = pend_q ? ST_ASSERT : ST_IDLE;
         ST_LAUNCH: state_d = ST_ASSERT;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         cur_idx_q   <= '0;
         cur_hold_q  <= 1'b0;
         pend_q      <= 1'b0;
         pend_idx_q  <= '0;
         pend_hold_q <= 1'b0;
         cs_act_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && req_valid) begin
            cur_idx_q  <= req_idx;
            cur_hold_q <= req_hold;
            cs_act_q   <= 1'b1;
         end
         if (state_q == ST_HOLD && req_valid) begin
            if (req_idx == cur_idx_q) begin
               cur_hold_q <= req_hold;
            end else begin
               pend_q      <= 1'b1;
               pend_idx_q  <= req_idx;
               pend_hold_q <= req_hold;
            end
         end
         if (state_q == ST_RELEASE)
            cs_act_q <= 1'b0;
         if (state_q == ST_LAUNCH || (state_q == ST_GAP && tmr_zero && pend_q)) begin
            cs_act_q   <= 1'b1;
            cur_idx_q  <= pend_idx_q;
            cur_hold_q <= pend_hold_q;
            pend_q     <= 1'b0;
         end
      end
   end

   cs_frame_decode #(.NUM_CS(NUM_CS), .ACTIVE_LOW(1'b1)) u_decode (
      .active (cs_act_q),
      .idx    (cur_idx_q),
      .lines  (cs_n)
   );

   assign req_ready = (state_q == ST_IDLE) || (state_q == ST_HOLD);
   assign busy      = ~req_ready;
   assign eng_start = (state_q == ST_START);

   assert_single_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~cs_n) <= 1);
   assert_start_has_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> (cs_n != '1));
   assert_start_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);
   assert_hold_keeps_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HOLD) |-> (cs_n != '1));
   assert_idle_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> (cs_n == '1 && !busy));
   assert_release_rises_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RELEASE) |=> (cs_n == '1));

endmodule

// File: tb/cs_frame_seq_bench.sv
module cs_frame_seq_bench;

   localparam int NCS = 8;
   localparam logic [NCS-1:0] ONES = '1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_idx = '0;
   logic        req_hold = 1'b0;
   logic        req_ready;
   logic [31:0] cfg_delay = '0;
   logic        cfg_timer_dis = 1'b0;
   logic        cfg_gap_en = 1'b0;
   logic [5:0]  cfg_gap = '0;
   logic        eng_done = 1'b0;
   logic        eng_start;
   logic [NCS-1:0] cs_n;
   logic        busy;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   cs_frame_seq u_cs_frame_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
      .req_hold(req_hold), .req_ready(req_ready), .cfg_delay(cfg_delay),
      .cfg_timer_dis(cfg_timer_dis), .cfg_gap_en(cfg_gap_en), .cfg_gap(cfg_gap),
      .eng_done(eng_done), .eng_start(eng_start), .cs_n(cs_n), .busy(busy)
   );

   function automatic logic [NCS-1:0] pat(int idx);
      return ~(NCS'(1) << idx);
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Request at a negedge; returns at the negedge right after acceptance.
   task automatic issue(int idx, bit hold);
      req_valid = 1'b1; req_idx = 3'(idx); req_hold = hold;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_start(output int k);
      k = 0;
      while (!eng_start && k < 600) begin @(negedge clk); k++; end
   endtask

   // Pulse done two cycles after start; returns at negedge after the done edge.
   task automatic finish_word();
      @(negedge clk);
      chk(!eng_start, "R10", eng_start, 0);
      @(negedge clk);
      eng_done = 1'b1;
      @(negedge clk);
      eng_done = 1'b0;
   endtask

   task automatic wait_release(output int k);
      k = 0;
      while (cs_n != ONES && k < 600) begin @(negedge clk); k++; end
   endtask

   task automatic full_word(int idx, int lead, int trail, bit tdis,
                            bit gen, int gap, logic [15:0] junk, string lreq);
      int k, el, et, eg;
      cfg_delay = {8'(lead), 8'(trail), junk};
      cfg_timer_dis = tdis; cfg_gap_en = gen; cfg_gap = 6'(gap);
      el = tdis ? 0 : lead;
      et = tdis ? 0 : trail;
      eg = gen ? gap : 0;
      issue(idx, 1'b0);
      chk(cs_n == pat(idx), "R2", int'(cs_n), int'(pat(idx)));
      chk(busy && !req_ready, "R11", busy, 1);
      wait_start(k);
      chk(k == el + 1, lreq, k, el + 1);
      finish_word();
      wait_release(k);
      chk(k == et + 1, lreq == "R5" ? "R5" : "R4", k, et + 1);
      k = 0;
      while (busy && k < 600) begin @(negedge clk); k++; end
      chk(k == eg, "R9", k, eg);
      chk(req_ready && cs_n == ONES, "R11", req_ready, 1);
   endtask

   initial begin : watchdog
      int cyc = 0;
      while (!finished) begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
         end
      end
   end

   initial begin : stim
      int k;
      repeat (3) @(negedge clk);
      chk(cs_n == ONES, "R1", int'(cs_n), int'(ONES));
      chk(!busy && !eng_start && req_ready, "R1", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cs_n == ONES && req_ready, "R1", int'(cs_n), int'(ONES));

      // R2/R3/R4/R9 sweep over lines, delays and gap
      for (int idx = 0; idx < NCS; idx++)
         for (int li = 0; li < 3; li++)
            for (int ti = 0; ti < 2; ti++)
               for (int g = 0; g < 2; g++)
                  full_word(idx, (li == 0) ? 0 : (li == 1 ? 1 : 3), ti * 2,
                            1'b0, 1'(g), 4, 16'h0000, "R3");

      // R6: low half of delay word varied, timing unchanged
      full_word(5, 2, 3, 1'b0, 1'b0, 0, 16'hFFFF, "R6");
      full_word(2, 2, 3, 1'b0, 1'b0, 0, 16'hA5C3, "R6");

      // R9: gap value ignored while disabled
      full_word(1, 1, 1, 1'b0, 1'b0, 9, 16'h0000, "R3");

      // R5: bypass with large fields
      full_word(4, 7, 9, 1'b1, 1'b0, 0, 16'h1234, "R5");
      full_word(0, 200, 150, 1'b1, 1'b1, 2, 16'h0000, "R5");

      // R7: hold then same line
      cfg_delay = {8'd2, 8'd3, 16'h0}; cfg_timer_dis = 1'b0;
      cfg_gap_en = 1'b0; cfg_gap = '0;
      issue(3, 1'b1);
      wait_start(k);
      chk(k == 3, "R3", k, 3);
      finish_word();
      chk(!busy && req_ready, "R7", busy, 0);
      chk(cs_n == pat(3), "R7", int'(cs_n), int'(pat(3)));
      repeat (4) @(negedge clk);
      chk(cs_n == pat(3), "R7", int'(cs_n), int'(pat(3)));
      issue(3, 1'b0);
      chk(eng_start == 1'b1, "R7", eng_start, 1);
      chk(cs_n == pat(3), "R7", int'(cs_n), int'(pat(3)));
      finish_word();
      wait_release(k);
      chk(k == 4, "R4", k, 4);

      // R8: hold then different line
      @(negedge clk);
      issue(1, 1'b1);
      wait_start(k);
      finish_word();
      chk(cs_n == pat(1) && !busy, "R7", int'(cs_n), int'(pat(1)));
      issue(6, 1'b0);
      chk(cs_n == pat(1) && busy, "R8", int'(cs_n), int'(pat(1)));
      wait_release(k);
      chk(k == 4, "R8", k, 4);
      @(negedge clk);
      chk(cs_n == pat(6), "R8", int'(cs_n), int'(pat(6)));
      wait_start(k);
      chk(k == 3, "R8", k, 3);
      finish_word();
      wait_release(k);
      chk(k == 4, "R4", k, 4);
      @(negedge clk);
      chk(!busy && cs_n == ONES, "R11", busy, 0);

      finished = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule